// File: doc/BRIEF.md
# Line-Locked Eight-Channel PWM DAC Bank

This block drives eight independent pulse-width-modulated outputs, each meant to feed an external RC filter that turns the pulse train into an analog control level. A host loads an 8-bit duty value per channel through a small register write stream (address plus data). Every channel compares its duty value against a shared 8-bit period counter. The counter advances once per prescaler cycle, so one PWM period lasts 256 prescaler cycles.

The period counter and the prescaler do not run freely. On every active horizontal sync edge they restart, so the pulse trains stay phase-locked to the video line. The prescaler also drives an exported PWM clock at the same phase, for external converters that need a line-locked clock. The sync input has a selectable polarity and passes through a two-flop synchronizer before edge detection. A new duty value is held in a staging register and moves into the live compare register only at the start of a period, so an output never shows a runt pulse.

The write stream uses valid/ready handshaking. `wr_ready` is held high at all times, so the block never applies back-pressure. A beat transfers on every clock edge where `wr_valid` is high.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset all PWM outputs are low, `pwm_clk_out` is high, `wr_ready` is high, and every staged and live duty value is 0.
- R2: A beat with `wr_valid` high and `wr_addr` in 0..7 stores `wr_data` as the staged duty of the channel with that index.
- R3: A beat whose `wr_addr` is 8 or above has no effect on any channel.
- R4: Let D be a channel's live duty. From a period start, the channel is high for the first D×PRESC_DIV clocks and low for the rest of the 256×PRESC_DIV-clock period. D=0 gives a constantly low output, and D=255 is low for the last PRESC_DIV clocks.
- R5: A staged duty becomes live only at the next period start. That start is either a counter wrap or a sync restart. A period already running keeps its old duty.
- R6: The active sync edge, once it reaches the third synchronizer stage (the third rising clock after the input changes), restarts the period counter and the prescaler. The live duties are reloaded in the same cycle.
- R7: `pwm_clk_out` has a period of PRESC_DIV clocks. It is high for the first PRESC_DIV/2 clocks after each prescaler restart.
- R8: With `hsync_pol`=0 a rising edge of `hsync_in` is active. With `hsync_pol`=1 a falling edge is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous to clk |
| hsync_pol | input | 1 | 0: rising edge active, 1: falling edge active |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready, held high |
| wr_addr | input | ADDR_W | Channel index of the write beat |
| wr_data | input | 8 | Duty value of the write beat |
| pwm_out | output | NCH | One PWM output per channel |
| pwm_clk_out | output | 1 | Line-locked PWM clock |

## Verification
Three tables of eight duties load all channels at once, followed by a sync restart. The tables include 0, 1, 255, and values next to the half-scale point. The bench checks where each output first drops after the restart, and this separates a correct compare from an off-by-one or a free-running counter. A duty rewritten in mid-period must leave that period unchanged and must appear in the next period, which begins from a counter wrap with no sync edge. A restart on a falling edge with the polarity inverted shows that the polarity select works. Writes to addresses above the channel range must leave every waveform as it was.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int DUTY_W = 8;
  typedef logic [DUTY_W-1:0] duty_t;
  localparam duty_t CNT_MAX = '1;
endpackage

// File: rtl/pwm_hsync_sync.sv
module pwm_hsync_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic hsync_pol,
  output logic line_start
);
  logic       hs_lvl;
  logic [2:0] hs_sh;

  assign hs_lvl = hsync_in ^ hsync_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_sh <= '0;
    else        hs_sh <= {hs_sh[1:0], hs_lvl};
  end

  assign line_start = hs_sh[1] & ~hs_sh[2];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start); // R6
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_dac_pkg::*;
#(
  parameter int PRESC_DIV = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_start,
  output duty_t count,
  output logic  period_start,
  output logic  pwm_clk
);
  localparam int PW   = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int HALF = PRESC_DIV / 2;

  logic [PW-1:0] presc;
  logic          tick;

  assign tick = (presc == PW'(PRESC_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      count <= '0;
    end else if (line_start) begin
      presc <= '0;
      count <= '0;
    end else if (tick) begin
      presc <= '0;
      count <= count + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  assign period_start = line_start | (tick & (count == CNT_MAX));
  assign pwm_clk      = (presc < PW'(HALF));

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    presc <= PW'(PRESC_DIV - 1)); // R7
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (count == '0 && presc == '0)); // R6
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == CNT_MAX) |=> (count == '0)); // R4
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_dac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  duty_t wr_data,
  input  logic  period_start,
  input  duty_t count,
  output logic  pwm_o
);
  duty_t staged;
  duty_t live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= '0;
      live   <= '0;
    end else begin
      if (wr_en)        staged <= wr_data;
      if (period_start) live   <= staged;
    end
  end

  assign pwm_o = (count < live);

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(live)); // R5
  AST_DUTY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> (live == $past(staged))); // R5
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int ADDR_W    = 4,
  parameter int PRESC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              hsync_pol,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NCH-1:0]    pwm_out,
  output logic              pwm_clk_out
);
  logic           line_start;
  logic           period_start;
  duty_t          count;
  logic [NCH-1:0] ch_we;

  assign wr_ready = 1'b1;

  pwm_hsync_sync u_sync (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hsync_pol(hsync_pol),
    .line_start(line_start)
  );

  pwm_timebase #(.PRESC_DIV(PRESC_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .count(count),
    .period_start(period_start), .pwm_clk(pwm_clk_out)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_we[g] = wr_valid & wr_ready & (wr_addr == ADDR_W'(g));
    pwm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(ch_we[g]), .wr_data(wr_data),
      .period_start(period_start), .count(count), .pwm_o(pwm_out[g])
    );
  end

  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr >= ADDR_W'(NCH)) |-> (ch_we == '0)); // R3
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_we) <= 1); // R2
endmodule

// File: tb/tb_pwm_dac_bank.sv
module tb_pwm_dac_bank;
  localparam int NCH = 8;
  localparam int AW  = 4;
  localparam int DIV = 4;
  localparam int PER = 256 * DIV;

  localparam logic [7:0] VEC [3][NCH] = '{
    '{8'd0,   8'd1, 8'd2,  8'd127, 8'd128, 8'd200, 8'd254, 8'd255},
    '{8'd255, 8'd0, 8'd17, 8'd64,  8'd33,  8'd99,  8'd250, 8'd5},
    '{8'd10,  8'd20, 8'd30, 8'd40, 8'd50,  8'd60,  8'd70,  8'd80}
  };

  logic clk = 0, rst_n = 0, hsync_in = 0, hsync_pol = 0, wr_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, pwm_clk_out;
  logic [NCH-1:0] pwm_out;
  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] exp_duty [NCH];

  always #2 clk = ~clk;

  pwm_dac_bank #(.NCH(NCH), .ADDR_W(AW), .PRESC_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hsync_pol(hsync_pol),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .pwm_clk_out(pwm_clk_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d[7:0];
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic align(input logic lvl);
    @(negedge clk);
    hsync_in = lvl;
    repeat (3) @(posedge clk);
  endtask

  task automatic release_sync(input logic lvl);
    @(negedge clk);
    hsync_in = lvl;
    repeat (7) @(negedge clk);
  endtask

  // Samples one full period from the current negedge; optional mid-period write.
  task automatic measure(input string req, input bit mid, input int ma, input int md);
    int first_low [NCH];
    int highs [NCH];
    int clk_pat;
    clk_pat = 0;
    for (int c = 0; c < NCH; c++) begin first_low[c] = PER; highs[c] = 0; end
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (mid && i == 100) begin wr_valid = 1; wr_addr = AW'(ma); wr_data = md[7:0]; end
      if (mid && i == 101) wr_valid = 0;
      if (i < DIV) clk_pat |= int'(pwm_clk_out) << i;
      for (int c = 0; c < NCH; c++) begin
        if (pwm_out[c]) highs[c]++;
        else if (first_low[c] == PER) first_low[c] = i;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      check($sformatf("%s ch%0d first-low", req, c), first_low[c],
            (exp_duty[c] == 0) ? 0 : int'(exp_duty[c]) * DIV);
      check($sformatf("%s ch%0d high-count", req, c), highs[c], int'(exp_duty[c]) * DIV);
    end
    check($sformatf("%s R7 pwm_clk phase", req), clk_pat, (1 << (DIV / 2)) - 1);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) exp_duty[c] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 pwm_clk_out", int'(pwm_clk_out), 1);
    check("R1 wr_ready", int'(wr_ready), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2/R4/R6 table walk
    for (int v = 0; v < 3; v++) begin
      for (int c = 0; c < NCH; c++) begin
        wr(c, VEC[v][c]);
        exp_duty[c] = VEC[v][c];
      end
      repeat (37 * v + 5) @(negedge clk);
      align(1'b1);
      measure("R2 R4 R6 table", 0, 0, 0);
      release_sync(1'b0);
    end

    // R3 out-of-range addresses ignored
    wr(8, 8'hFF);
    wr(15, 8'hAA);
    wr(11, 8'h01);
    align(1'b1);
    measure("R3 bad-addr", 0, 0, 0);
    release_sync(1'b0);

    // R5 mid-period rewrite held until next period (counter wrap)
    align(1'b1);
    measure("R5 old-duty", 1, 0, 200);
    exp_duty[0] = 200;
    measure("R5 new-duty-at-wrap", 0, 0, 0);
    release_sync(1'b0);

    // R8 inverted polarity: falling edge restarts
    @(negedge clk);
    hsync_in = 1'b1;
    hsync_pol = 1'b1;
    repeat (9) @(negedge clk);
    wr(3, 8'd3);
    exp_duty[3] = 3;
    repeat (13) @(negedge clk);
    align(1'b0);
    measure("R8 falling-edge", 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule